// File: doc/BRIEF.md
# Cache Hierarchy Statistics Accumulator

This block keeps running statistics for a three-level cache hierarchy. It sits beside the caches. For every completed processor request it receives a single-cycle completion pulse. The pulse carries the deepest level the request reached and whether that level held the block. From this the block counts, for each level, how many probes reached it, how many of those hit and how many missed. It also counts processor requests and keeps a cycle total in which every probe is weighted by the latency of its level.

Software or a debug agent reads the counters one at a time through a registered select port. Ratios are not computed in hardware; each one is formed off-block from two counters. The per-level hit rate is hits over accesses. The local miss rate is misses over that level's accesses. The global miss rate is misses over the request count. A synchronous clear input zeroes every counter at once. All counters saturate at their maximum value instead of wrapping.

Top module: `cache_stats_acc`

## Requirements
- R1: After reset, and one cycle after `stat_clr` is sampled high, every counter reads 0. A clear wins over a completion pulse in the same cycle, so that pulse is not counted.
- R2: The request counter (select 0) rises by exactly one for every cycle in which `req_valid` is sampled high, including back-to-back pulses.
- R3: `req_depth` encodes the deepest level probed: 0 = L1, 1 = L2, 2 = L3; the value 3 is never presented. The access counter of level i (selects 1, 2, 3 for L1, L2, L3) rises by one when `req_depth` >= i. An L1 hit therefore touches only the L1 counters, while a depth-2 request touches all three access counters.
- R4: The hit counter of level i (selects 4, 5, 6) rises by one only when `req_depth` == i and `req_hit` is 1.
- R5: The miss counter of level i (selects 7, 8, 9) rises by one for every level shallower than `req_depth`. It also rises for the deepest probed level itself when `req_hit` is 0.
- R6: The cycle total (select 10) grows, in the cycle of the completion pulse, by the sum of `LAT_L1`, `LAT_L2`, `LAT_L3` over the probed levels. With the default latencies of 3, 11 and 25, the increments are 3, 14 and 39 for depths 0, 1 and 2.
- R7: Every counter stops at 2^`CNT_W`-1 and holds there until cleared. The default `CNT_W` of 20 holds 1024 requests times the sum of the latencies.
- R8: `rd_data` presents the counter chosen by `rd_sel` one clock after the select is sampled. Select codes 11 to 15 return 0.
- R9: While `req_valid` is low, `req_depth` and `req_hit` have no effect on any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_clr | input | 1 | Synchronous clear of all counters |
| req_valid | input | 1 | Completion pulse, one per finished request |
| req_depth | input | 2 | Deepest level probed (0 = L1, 1 = L2, 2 = L3) |
| req_hit | input | 1 | Deepest probed level held the block |
| rd_sel | input | 4 | Counter select |
| rd_data | output | CNT_W | Selected counter, registered |

## Verification
The bench first sends runs of pure L1 hits. These separate the request count from the deeper levels' counters, which must stay at zero. It then sends hits at L2 and at L3 and full misses through all three levels. These show whether each shallower level is charged with a miss and whether the latency sum grows by the right per-depth amount. Back-to-back pulses with a changing depth test per-cycle accounting, and a run of idle cycles with toggling depth and hit inputs tests that nothing is counted without a pulse. A clear that lands on a pulse, and a run of more than 2^`CNT_W` full misses on a narrowed instance, cover clear priority and saturation.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
    localparam int NUM_LVL = 3;
    localparam int SEL_W   = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_REQ   = 4'd0,
        SEL_ACC1  = 4'd1,
        SEL_ACC2  = 4'd2,
        SEL_ACC3  = 4'd3,
        SEL_HIT1  = 4'd4,
        SEL_HIT2  = 4'd5,
        SEL_HIT3  = 4'd6,
        SEL_MISS1 = 4'd7,
        SEL_MISS2 = 4'd8,
        SEL_MISS3 = 4'd9,
        SEL_CYC   = 4'd10
    } stat_sel_e;

    localparam int NUM_SEL = 11;
endpackage

// File: rtl/cstat_sat_counter.sv
module cstat_sat_counter #(
    parameter int W     = 20,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     q
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, q} + {{(W+1-INC_W){1'b0}}, inc};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= sum[W] ? MAXV : sum[W-1:0];
        end
    end

    // R1: a clear empties the counter on the next edge
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

    // R7: without a clear the value never goes down (no wrap)
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (q >= $past(q)));

    // R7: a full counter stays full until cleared
    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && q == MAXV) |=> (q == MAXV));
endmodule

// File: rtl/cstat_lvl_decode.sv
module cstat_lvl_decode
    import cstat_pkg::*;
#(
    parameter int LAT_L1 = 3,
    parameter int LAT_L2 = 11,
    parameter int LAT_L3 = 25,
    parameter int INC_W  = 6
) (
    input  logic               req_valid,
    input  logic [1:0]         req_depth,
    input  logic               req_hit,
    output logic [NUM_LVL-1:0] acc_en,
    output logic [NUM_LVL-1:0] hit_en,
    output logic [NUM_LVL-1:0] miss_en,
    output logic [INC_W-1:0]   cyc_inc
);
    localparam int LAT [NUM_LVL] = '{LAT_L1, LAT_L2, LAT_L3};

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
        logic probed;
        logic deepest;
        assign probed     = req_valid && (int'(req_depth) >= i);
        assign deepest    = (int'(req_depth) == i);
        assign acc_en[i]  = probed;
        assign hit_en[i]  = probed && deepest && req_hit;
        assign miss_en[i] = probed && !(deepest && req_hit);
    end

    always_comb begin
        cyc_inc = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (acc_en[i]) cyc_inc = cyc_inc + INC_W'(LAT[i]);
        end
    end
endmodule

// File: rtl/cstat_rd_port.sv
module cstat_rd_port
    import cstat_pkg::*;
#(
    parameter int W = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SEL_W-1:0]          rd_sel,
    input  logic [NUM_SEL-1:0][W-1:0] vals,
    output logic [W-1:0]              rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (int'(rd_sel) < NUM_SEL) begin
            rd_data <= vals[rd_sel];
        end else begin
            rd_data <= '0;
        end
    end

    // R8: reserved codes read as zero one cycle later
    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_sel) >= NUM_SEL) |=> (rd_data == '0));
endmodule

// File: rtl/cache_stats_acc.sv
module cache_stats_acc
    import cstat_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int LAT_L1 = 3,
    parameter int LAT_L2 = 11,
    parameter int LAT_L3 = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_clr,
    input  logic             req_valid,
    input  logic [1:0]       req_depth,
    input  logic             req_hit,
    input  logic [3:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data
);
    localparam int LAT_SUM = LAT_L1 + LAT_L2 + LAT_L3;
    localparam int INC_W   = $clog2(LAT_SUM + 1);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [NUM_LVL-1:0] acc_en, hit_en, miss_en;
    logic [INC_W-1:0]   cyc_inc;
    logic [CNT_W-1:0]   req_cnt, cyc_cnt;
    logic [CNT_W-1:0]   acc_cnt  [NUM_LVL];
    logic [CNT_W-1:0]   hit_cnt  [NUM_LVL];
    logic [CNT_W-1:0]   miss_cnt [NUM_LVL];
    logic [NUM_SEL-1:0][CNT_W-1:0] vals;

    cstat_lvl_decode #(
        .LAT_L1 (LAT_L1),
        .LAT_L2 (LAT_L2),
        .LAT_L3 (LAT_L3),
        .INC_W  (INC_W)
    ) u_dec (
        .req_valid (req_valid),
        .req_depth (req_depth),
        .req_hit   (req_hit),
        .acc_en    (acc_en),
        .hit_en    (hit_en),
        .miss_en   (miss_en),
        .cyc_inc   (cyc_inc)
    );

    cstat_sat_counter #(.W(CNT_W), .INC_W(1)) u_req (
        .clk (clk), .rst_n (rst_n), .clr (stat_clr),
        .en  (req_valid), .inc (1'b1), .q (req_cnt)
    );

    cstat_sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_cyc (
        .clk (clk), .rst_n (rst_n), .clr (stat_clr),
        .en  (req_valid), .inc (cyc_inc), .q (cyc_cnt)
    );

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
        cstat_sat_counter #(.W(CNT_W), .INC_W(1)) u_acc (
            .clk (clk), .rst_n (rst_n), .clr (stat_clr),
            .en  (acc_en[i]), .inc (1'b1), .q (acc_cnt[i])
        );
        cstat_sat_counter #(.W(CNT_W), .INC_W(1)) u_hit (
            .clk (clk), .rst_n (rst_n), .clr (stat_clr),
            .en  (hit_en[i]), .inc (1'b1), .q (hit_cnt[i])
        );
        cstat_sat_counter #(.W(CNT_W), .INC_W(1)) u_miss (
            .clk (clk), .rst_n (rst_n), .clr (stat_clr),
            .en  (miss_en[i]), .inc (1'b1), .q (miss_cnt[i])
        );

        // R5: below saturation every probe is either a hit or a miss
        assert_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_cnt[i] != MAXV) |->
            ({1'b0, hit_cnt[i]} + {1'b0, miss_cnt[i]} == {1'b0, acc_cnt[i]}));

        // R4: hits never outnumber probes at a level
        assert_hit_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
            hit_cnt[i] <= acc_cnt[i]);
    end

    always_comb begin
        vals = '0;
        vals[SEL_REQ] = req_cnt;
        vals[SEL_CYC] = cyc_cnt;
        for (int i = 0; i < NUM_LVL; i++) begin
            vals[int'(SEL_ACC1)  + i] = acc_cnt[i];
            vals[int'(SEL_HIT1)  + i] = hit_cnt[i];
            vals[int'(SEL_MISS1) + i] = miss_cnt[i];
        end
    end

    cstat_rd_port #(.W(CNT_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (rd_sel),
        .vals    (vals),
        .rd_data (rd_data)
    );

    // R3: depth code 3 is never presented with a pulse
    assert_depth_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_depth != 2'd3));

    // R3: deeper levels are probed no more often than shallower ones
    assert_nested_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cnt[1] <= acc_cnt[0]) && (acc_cnt[2] <= acc_cnt[1]));

    // R8: request count appears on the port one edge after its select
    assert_read_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_REQ) |=> (rd_data == $past(req_cnt)));

    // R6: the latency total is never below the L1 share of the probes
    assert_cyc_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt != MAXV && acc_cnt[0] != MAXV) |->
        ({4'd0, cyc_cnt} >= (CNT_W+4)'(LAT_L1) * {4'd0, acc_cnt[0]}));
endmodule

// File: tb/tb_cache_stats_acc.sv
`timescale 1ns/1ps
module tb_cache_stats_acc;
    localparam int CW   = 10;
    localparam int MAXV = (1 << CW) - 1;
    localparam int LAT [3] = '{3, 11, 25};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stat_clr = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_depth = 2'd0;
    logic          req_hit = 1'b0;
    logic [3:0]    rd_sel = 4'd0;
    logic [CW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int e_req, e_cyc;
    int e_acc [3];
    int e_hit [3];
    int e_miss [3];

    always #4 clk = ~clk;

    cache_stats_acc #(.CNT_W(CW), .LAT_L1(3), .LAT_L2(11), .LAT_L3(25)) dut (
        .clk (clk), .rst_n (rst_n), .stat_clr (stat_clr),
        .req_valid (req_valid), .req_depth (req_depth), .req_hit (req_hit),
        .rd_sel (rd_sel), .rd_data (rd_data)
    );

    function automatic int sat(input int a, input int b);
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction

    task automatic model_zero();
        e_req = 0; e_cyc = 0;
        for (int i = 0; i < 3; i++) begin
            e_acc[i] = 0; e_hit[i] = 0; e_miss[i] = 0;
        end
    endtask

    task automatic model_req(input int d, input bit h);
        e_req = sat(e_req, 1);
        for (int i = 0; i < 3; i++) begin
            if (i <= d) begin
                e_acc[i] = sat(e_acc[i], 1);
                e_cyc    = sat(e_cyc, LAT[i]);
                if (i == d && h) e_hit[i] = sat(e_hit[i], 1);
                else             e_miss[i] = sat(e_miss[i], 1);
            end
        end
    endtask

    function automatic int expect_of(input int s);
        if (s == 0)  return e_req;
        if (s <= 3)  return e_acc[s-1];
        if (s <= 6)  return e_hit[s-4];
        if (s <= 9)  return e_miss[s-7];
        if (s == 10) return e_cyc;
        return 0;
    endfunction

    task automatic check(input string tag, input int s, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s sel=%0d actual=%0d expected=%0d", tag, s, got, exp);
        end
    endtask

    // reads all 16 select codes; reserved ones must be 0 (R8)
    task automatic check_all(input string tag);
        for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            rd_sel = 4'(s);
            @(negedge clk);
            check(tag, s, int'(rd_data), expect_of(s));
        end
    endtask

    task automatic pulse(input int d, input bit h);
        @(negedge clk);
        req_valid = 1'b1; req_depth = 2'(d); req_hit = h;
        @(negedge clk);
        req_valid = 1'b0;
        model_req(d, h);
    endtask

    task automatic do_clear();
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        model_zero();
    endtask

    // R1: reset state
    task automatic t_reset();
        model_zero();
        check_all("R1_reset");
    endtask

    // R2 R3 R4 R6: L1 hits leave deeper levels untouched
    task automatic t_l1_hits();
        for (int k = 0; k < 5; k++) pulse(0, 1'b1);
        check_all("R3_R4_l1hit");
    endtask

    // R4 R5 R6: hits at L2 and L3, full misses
    task automatic t_deep();
        pulse(1, 1'b1);
        pulse(2, 1'b1);
        pulse(2, 1'b1);
        pulse(2, 1'b0);
        pulse(1, 1'b0);
        pulse(0, 1'b0);
        check_all("R5_R6_deep");
    endtask

    // R2: back-to-back pulses with changing depth
    task automatic t_burst();
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            req_valid = 1'b1; req_depth = 2'(k % 3); req_hit = k[0];
            model_req(k % 3, k[0]);
            @(negedge clk);
        end
        req_valid = 1'b0;
        check_all("R2_burst");
    endtask

    // R9: inputs toggling while req_valid is low
    task automatic t_idle();
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            req_depth = 2'(k % 3); req_hit = ~req_hit;
        end
        check_all("R9_idle");
    endtask

    // R1: clear, and clear winning over a simultaneous pulse
    task automatic t_clear();
        do_clear();
        check_all("R1_clear");
        pulse(1, 1'b1);
        @(negedge clk);
        stat_clr = 1'b1; req_valid = 1'b1; req_depth = 2'd2; req_hit = 1'b0;
        @(negedge clk);
        stat_clr = 1'b0; req_valid = 1'b0;
        model_zero();
        check_all("R1_clr_wins");
    endtask

    // R7: more than 2^CW full misses drive everything to the ceiling
    task automatic t_saturate();
        @(negedge clk);
        req_valid = 1'b1; req_depth = 2'd2; req_hit = 1'b0;
        for (int k = 0; k < MAXV + 8; k++) begin
            model_req(2, 1'b0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        check_all("R7_sat");
        pulse(0, 1'b1);
        check_all("R7_sat_hold");
        do_clear();
        pulse(2, 1'b1);
        check_all("R7_after_clear");
    endtask

    initial begin
        model_zero();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_l1_hits();
        t_deep();
        t_burst();
        t_idle();
        t_clear();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule